// File: doc/BRIEF.md
# Floating-Point Compare Condition Unit

This block orders two IEEE-754 operands and records the outcome as a two-bit condition code inside a status register. A 32-bit instruction word comes in with a valid strobe. A nine-bit selector field inside that word picks one of four compare flavours: quiet or signaling, and single or double precision. Single precision is always present. Double precision is a build-time option.

A quiet compare records "unordered" when either operand is NaN. A signaling compare that meets a NaN leaves the condition untouched and instead pulses an invalid-operation flag. Any selector that names no compare pulses an illegal-operation flag. The status register lives in the block, resets to zero, and is presented on an output port. Surrounding logic can therefore branch on bits 11:10.

Top module: `fcc_compare_unit`

## Requirements
- R1: The selector is instruction bits 13:5. Value 0x51 is a quiet single compare, 0x52 a quiet double compare, 0x55 a signaling single compare and 0x56 a signaling double compare. Any other value, presented with the strobe, raises `illegal_op` for one cycle and leaves the status register unchanged.
- R2: The condition is written to status bits 11:10 on the rising clock edge after the strobe. The codes are 0 for equal, 1 for first operand smaller, 2 for first operand larger and 3 for unordered.
- R3: An operand is NaN when its exponent is all ones and its fraction is nonzero. A quiet compare with a NaN operand writes 3. Infinities compare as ordered values.
- R4: A signaling compare with a NaN operand keeps the previous condition and raises `invalid_exc` for one cycle.
- R5: Positive zero and negative zero compare equal.
- R6: Ordering follows sign and magnitude. A negative operand is below a positive one. Between two negatives, the one with the larger magnitude is the smaller value.
- R7: A single compare uses only bits 31:0 of each operand, and bits 63:32 have no effect. A double compare uses all 64 bits.
- R8: The status register resets to zero. Only bits 11:10 are ever written, so every other bit stays zero.
- R9: While the strobe is low, the status register holds its value and both flags stay low.
- R10: The two flags are one-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Strobe: the instruction and operands are valid this cycle |
| instr | input | 32 | Instruction word; bits 13:5 select the compare flavour |
| src_a | input | 64 | First operand (single precision in bits 31:0) |
| src_b | input | 64 | Second operand (single precision in bits 31:0) |
| stat_q | output | 32 | Status register; condition code in bits 11:10 |
| illegal_op | output | 1 | Pulse: unrecognised selector |
| invalid_exc | output | 1 | Pulse: signaling compare met a NaN |

## Verification
All the compare state sits in one register, so a fault shows up as a wrong code in bits 11:10, or a stray flag, one edge after the strobe. The bench checks every vector at that edge. A wrong code also persists until the next successful write. So does a write that should have been suppressed, after a signaling NaN or an illegal selector. The suppression vectors are placed directly after writes with different codes, so that a missed hold is visible. Swapped sign handling or a misplaced zero test shows only on operand pairs built for that case: two negatives, opposite zeros, and infinities. These pairs are all in the table.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

   // Condition code values as stored in the status register
   typedef enum logic [1:0] {
      CC_EQ = 2'd0,
      CC_LT = 2'd1,
      CC_GT = 2'd2,
      CC_UN = 2'd3
   } fcc_cond_e;

   // Decoded operation
   typedef struct packed {
      logic legal;   // selector names a supported compare
      logic dbl;     // double-precision operands
      logic sig;     // signaling flavour: NaN traps
   } fcc_op_t;

   localparam int unsigned SEL_W = 9;
   localparam logic [SEL_W-1:0] SEL_QUIET_SP = 9'h051;
   localparam logic [SEL_W-1:0] SEL_QUIET_DP = 9'h052;
   localparam logic [SEL_W-1:0] SEL_SIG_SP   = 9'h055;
   localparam logic [SEL_W-1:0] SEL_SIG_DP   = 9'h056;

endpackage

// File: rtl/fcc_op_decode.sv
module fcc_op_decode
   import fcc_pkg::*;
#(
   parameter int unsigned INSTR_W = 32,
   parameter int unsigned SEL_LSB = 5,
   parameter bit          DBL_EN  = 1'b1
) (
   input  logic [INSTR_W-1:0] instr,
   output fcc_op_t            op
);

   localparam int unsigned SEL_MSB = SEL_LSB + SEL_W - 1;

   if (SEL_MSB >= INSTR_W) begin : g_bad_sel
      initial $fatal(1, "fcc_op_decode: selector field exceeds instruction width");
   end

   logic [SEL_W-1:0] sel;
   logic             hit_sp_q, hit_sp_s, hit_dp_q, hit_dp_s;

   assign sel      = instr[SEL_MSB:SEL_LSB];
   assign hit_sp_q = (sel == SEL_QUIET_SP);
   assign hit_sp_s = (sel == SEL_SIG_SP);

   if (DBL_EN) begin : g_dp_dec
      assign hit_dp_q = (sel == SEL_QUIET_DP);
      assign hit_dp_s = (sel == SEL_SIG_DP);
   end else begin : g_no_dp_dec
      assign hit_dp_q = 1'b0;
      assign hit_dp_s = 1'b0;
   end

   always_comb begin
      op.legal = hit_sp_q | hit_sp_s | hit_dp_q | hit_dp_s;
      op.dbl   = hit_dp_q | hit_dp_s;
      op.sig   = hit_sp_s | hit_dp_s;
   end

   // R1: at most one selector match, so no flavour is ambiguous
   always_comb begin
      if (!$isunknown(instr))
         assert_single_match_R1: assert ($onehot0({hit_sp_q, hit_sp_s, hit_dp_q, hit_dp_s}))
            else $error("selector matched more than one compare flavour");
   end

endmodule

// File: rtl/fcc_nan_detect.sv
module fcc_nan_detect #(
   parameter int unsigned EXP_W  = 8,
   parameter int unsigned FRAC_W = 23,
   localparam int unsigned VAL_W = 1 + EXP_W + FRAC_W
) (
   input  logic [VAL_W-1:0] val,
   output logic             is_nan
);

   if (EXP_W < 2 || FRAC_W < 1) begin : g_bad_fmt
      initial $fatal(1, "fcc_nan_detect: format too narrow");
   end

   logic [EXP_W-1:0]  exp_f;
   logic [FRAC_W-1:0] frac_f;

   assign exp_f  = val[FRAC_W +: EXP_W];
   assign frac_f = val[FRAC_W-1:0];
   // R3: all-ones exponent with a nonzero fraction; an infinity has a zero fraction
   assign is_nan = (&exp_f) && (|frac_f);

endmodule

// File: rtl/fcc_magcmp.sv
module fcc_magcmp
   import fcc_pkg::*;
#(
   parameter int unsigned W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output fcc_cond_e    rel
);

   if (W < 3) begin : g_bad_w
      initial $fatal(1, "fcc_magcmp: width too small");
   end

   logic         sgn_a, sgn_b;
   logic [W-2:0] mag_a, mag_b;
   logic         both_zero, same_bits, mag_lt;

   assign sgn_a     = a[W-1];
   assign sgn_b     = b[W-1];
   assign mag_a     = a[W-2:0];
   assign mag_b     = b[W-2:0];
   assign both_zero = (mag_a == '0) && (mag_b == '0);
   assign same_bits = (a == b);
   assign mag_lt    = (mag_a < mag_b);

   always_comb begin
      if (both_zero || same_bits) begin
         rel = CC_EQ;                        // R5: zeros of either sign
      end else if (sgn_a != sgn_b) begin
         rel = sgn_a ? CC_LT : CC_GT;        // R6: negative below positive
      end else if (!sgn_a) begin
         rel = mag_lt ? CC_LT : CC_GT;
      end else begin
         rel = mag_lt ? CC_GT : CC_LT;       // R6: both negative, order reversed
      end
   end

   // R2: the ordered path never produces the unordered code
   always_comb begin
      if (!$isunknown({a, b}))
         assert_ordered_only_R2: assert (rel != CC_UN)
            else $error("magnitude compare produced unordered");
   end

endmodule

// File: rtl/fcc_compare_unit.sv
module fcc_compare_unit
   import fcc_pkg::*;
#(
   parameter int unsigned INSTR_W   = 32,
   parameter int unsigned SEL_LSB   = 5,
   parameter int unsigned OPND_W    = 64,
   parameter int unsigned STAT_W    = 32,
   parameter int unsigned CC_LSB    = 10,
   parameter bit          DBL_EN    = 1'b1,
   parameter int unsigned SP_EXP_W  = 8,
   parameter int unsigned SP_FRAC_W = 23,
   parameter int unsigned DP_EXP_W  = 11,
   parameter int unsigned DP_FRAC_W = 52
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               op_valid,
   input  logic [INSTR_W-1:0] instr,
   input  logic [OPND_W-1:0]  src_a,
   input  logic [OPND_W-1:0]  src_b,
   output logic [STAT_W-1:0]  stat_q,
   output logic               illegal_op,
   output logic               invalid_exc
);

   localparam int unsigned SP_W = 1 + SP_EXP_W + SP_FRAC_W;
   localparam int unsigned DP_W = 1 + DP_EXP_W + DP_FRAC_W;
   localparam logic [STAT_W-1:0] CC_MASK = {{(STAT_W-2){1'b0}}, 2'b11} << CC_LSB;

   // Elaboration-time parameter checks
   if (CC_LSB + 2 > STAT_W) begin : g_bad_cc
      initial $fatal(1, "fcc_compare_unit: condition field outside status register");
   end
   if (SP_W > OPND_W) begin : g_bad_sp
      initial $fatal(1, "fcc_compare_unit: operand port narrower than single format");
   end
   if (DBL_EN && (DP_W > OPND_W)) begin : g_bad_dp
      initial $fatal(1, "fcc_compare_unit: operand port narrower than double format");
   end

   // Decode
   fcc_op_t op;

   fcc_op_decode #(
      .INSTR_W (INSTR_W),
      .SEL_LSB (SEL_LSB),
      .DBL_EN  (DBL_EN)
   ) u_dec (
      .instr (instr),
      .op    (op)
   );

   // Single-precision path (R7: low bits only)
   logic      nan_a_sp, nan_b_sp;
   fcc_cond_e rel_sp;

   fcc_nan_detect #(.EXP_W(SP_EXP_W), .FRAC_W(SP_FRAC_W)) u_nan_a_sp (
      .val (src_a[SP_W-1:0]), .is_nan (nan_a_sp));
   fcc_nan_detect #(.EXP_W(SP_EXP_W), .FRAC_W(SP_FRAC_W)) u_nan_b_sp (
      .val (src_b[SP_W-1:0]), .is_nan (nan_b_sp));
   fcc_magcmp #(.W(SP_W)) u_cmp_sp (
      .a (src_a[SP_W-1:0]), .b (src_b[SP_W-1:0]), .rel (rel_sp));

   // Double-precision path, present only when enabled
   logic      nan_a_dp, nan_b_dp;
   fcc_cond_e rel_dp;

   if (DBL_EN) begin : g_dp
      fcc_nan_detect #(.EXP_W(DP_EXP_W), .FRAC_W(DP_FRAC_W)) u_nan_a_dp (
         .val (src_a[DP_W-1:0]), .is_nan (nan_a_dp));
      fcc_nan_detect #(.EXP_W(DP_EXP_W), .FRAC_W(DP_FRAC_W)) u_nan_b_dp (
         .val (src_b[DP_W-1:0]), .is_nan (nan_b_dp));
      fcc_magcmp #(.W(DP_W)) u_cmp_dp (
         .a (src_a[DP_W-1:0]), .b (src_b[DP_W-1:0]), .rel (rel_dp));
   end else begin : g_no_dp
      assign nan_a_dp = 1'b0;
      assign nan_b_dp = 1'b0;
      assign rel_dp   = CC_EQ;
   end

   // Result selection
   logic      any_nan, do_write, set_ill, set_exc;
   fcc_cond_e cc_new;

   assign any_nan  = op.dbl ? (nan_a_dp | nan_b_dp) : (nan_a_sp | nan_b_sp);
   assign cc_new   = any_nan ? CC_UN : (op.dbl ? rel_dp : rel_sp);
   assign set_ill  = op_valid && !op.legal;
   assign set_exc  = op_valid && op.legal && op.sig && any_nan;
   assign do_write = op_valid && op.legal && !(op.sig && any_nan);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_q      <= '0;
         illegal_op  <= 1'b0;
         invalid_exc <= 1'b0;
      end else begin
         illegal_op  <= set_ill;
         invalid_exc <= set_exc;
         if (do_write)
            stat_q[CC_LSB +: 2] <= cc_new;
      end
   end

   // R3: quiet compare with a NaN lands on the unordered code
   assert_quiet_nan_unordered_R3: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && op.legal && !op.sig && any_nan |=> stat_q[CC_LSB +: 2] == CC_UN)
      else $error("quiet NaN compare did not record unordered");

   // R4: a signaling trap leaves the condition where it was
   assert_trap_holds_cc_R4: assert property (@(posedge clk) disable iff (!rst_n)
      invalid_exc |-> $stable(stat_q))
      else $error("condition changed on a signaling trap");

   // R1: an illegal selector leaves the condition where it was
   assert_illegal_holds_cc_R1: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_op |-> $stable(stat_q))
      else $error("condition changed on an illegal selector");

   // R8: bits outside the condition field never move
   assert_other_bits_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> $stable(stat_q & ~CC_MASK))
      else $error("status bit outside the condition field changed");

   // R9: no strobe, no change and no flag
   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> $stable(stat_q) && !illegal_op && !invalid_exc)
      else $error("activity without a strobe");

   // R10: flags never coincide
   assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(illegal_op && invalid_exc))
      else $error("both flags high");

endmodule

// File: tb/fcc_compare_unit_tb.sv
module fcc_compare_unit_tb_top;

   localparam time TCLK = 20ns;   // 50 MHz

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [31:0] instr = '0;
   logic [63:0] src_a = '0;
   logic [63:0] src_b = '0;
   logic [31:0] stat_q;
   logic        illegal_op, invalid_exc;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(TCLK/2) clk = ~clk;

   fcc_compare_unit dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .op_valid    (op_valid),
      .instr       (instr),
      .src_a       (src_a),
      .src_b       (src_b),
      .stat_q      (stat_q),
      .illegal_op  (illegal_op),
      .invalid_exc (invalid_exc)
   );

   typedef struct packed {
      logic [7:0]  req;
      logic [8:0]  sel;
      logic [63:0] a;
      logic [63:0] b;
      logic [1:0]  cc;
      logic        ill;
      logic        exc;
   } vec_t;

   localparam int NV = 20;
   // Single-precision vectors carry different junk in bits 63:32 (R7)
   localparam vec_t VECS [NV] = '{
      '{8'd6,  9'h051, 64'hDEADBEEF_3F800000, 64'h0BADF00D_40000000, 2'd1, 1'b0, 1'b0}, // R6 1<2
      '{8'd2,  9'h051, 64'hDEADBEEF_40000000, 64'h0BADF00D_3F800000, 2'd2, 1'b0, 1'b0}, // R2 2>1
      '{8'd2,  9'h051, 64'hDEADBEEF_3F800000, 64'h0BADF00D_3F800000, 2'd0, 1'b0, 1'b0}, // R2 equal
      '{8'd6,  9'h051, 64'hDEADBEEF_BF800000, 64'h0BADF00D_C0000000, 2'd2, 1'b0, 1'b0}, // R6 -1>-2
      '{8'd6,  9'h051, 64'hDEADBEEF_C0000000, 64'h0BADF00D_BF800000, 2'd1, 1'b0, 1'b0}, // R6 -2<-1
      '{8'd5,  9'h051, 64'hDEADBEEF_00000000, 64'h0BADF00D_80000000, 2'd0, 1'b0, 1'b0}, // R5 +0==-0
      '{8'd6,  9'h051, 64'hDEADBEEF_BF800000, 64'h0BADF00D_00000000, 2'd1, 1'b0, 1'b0}, // R6 -1<+0
      '{8'd3,  9'h051, 64'hDEADBEEF_7FC00000, 64'h0BADF00D_3F800000, 2'd3, 1'b0, 1'b0}, // R3 NaN
      '{8'd3,  9'h051, 64'hDEADBEEF_7F800000, 64'h0BADF00D_40000000, 2'd2, 1'b0, 1'b0}, // R3 inf ordered
      '{8'd4,  9'h055, 64'hDEADBEEF_3F800000, 64'h0BADF00D_7F800001, 2'd2, 1'b0, 1'b1}, // R4 trap, hold
      '{8'd6,  9'h055, 64'hDEADBEEF_FF800000, 64'h0BADF00D_BF800000, 2'd1, 1'b0, 1'b0}, // R6 -inf<-1
      '{8'd1,  9'h052, 64'h40000000_00000000, 64'h3FF00000_00000000, 2'd2, 1'b0, 1'b0}, // R1 quiet dp
      '{8'd3,  9'h052, 64'h3FF00000_00000000, 64'h7FF80000_00000000, 2'd3, 1'b0, 1'b0}, // R3 dp NaN
      '{8'd1,  9'h056, 64'hBFF00000_00000000, 64'hBFF00000_00000000, 2'd0, 1'b0, 1'b0}, // R1 sig dp
      '{8'd4,  9'h056, 64'h7FF80000_00000000, 64'h3FF00000_00000000, 2'd0, 1'b0, 1'b1}, // R4 dp trap
      '{8'd1,  9'h053, 64'h3FF00000_00000000, 64'h40000000_00000000, 2'd0, 1'b1, 1'b0}, // R1 illegal
      '{8'd1,  9'h000, 64'h00000000_3F800000, 64'h00000000_40000000, 2'd0, 1'b1, 1'b0}, // R1 illegal
      '{8'd7,  9'h051, 64'h00000000_40000000, 64'hFFF00000_3F800000, 2'd2, 1'b0, 1'b0}, // R7 high ignored
      '{8'd7,  9'h052, 64'h3FF00000_00000000, 64'h3FF00000_00000001, 2'd1, 1'b0, 1'b0}, // R7 dp full width
      '{8'd6,  9'h056, 64'h7FF00000_00000000, 64'hFFF00000_00000000, 2'd2, 1'b0, 1'b0}  // R6 +inf>-inf
   };

   function automatic logic [31:0] mk_instr(input logic [8:0] sel);
      return 32'h81A0_0013 | (32'(sel) << 5);
   endfunction

   task automatic check(input string tag, input logic [33:0] act, input logic [33:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual {stat,ill,exc}=%h expected %h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin : stim
      logic [31:0] exp_stat;
      // Reset state (R8)
      repeat (3) @(negedge clk);
      check("R8 reset value", {stat_q, illegal_op, invalid_exc}, 34'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9 idle after reset", {stat_q, illegal_op, invalid_exc}, 34'd0);

      // Vector table, back to back
      for (int i = 0; i < NV; i++) begin
         op_valid = 1'b1;
         instr    = mk_instr(VECS[i].sel);
         src_a    = VECS[i].a;
         src_b    = VECS[i].b;
         @(negedge clk);
         exp_stat = 32'(VECS[i].cc) << 10;
         check($sformatf("R%0d vector %0d", VECS[i].req, i),
               {stat_q, illegal_op, invalid_exc},
               {exp_stat, VECS[i].ill, VECS[i].exc});
      end

      // R9/R10: strobe low, flags drop, condition held (last code 2)
      op_valid = 1'b0;
      instr    = mk_instr(9'h051);
      src_a    = 64'h0;
      src_b    = 64'h0;
      @(negedge clk);
      check("R10 pulse ends", {stat_q, illegal_op, invalid_exc}, {32'h0000_0800, 2'b00});
      instr = mk_instr(9'h1FF);
      @(negedge clk);
      check("R9 idle illegal selector ignored", {stat_q, illegal_op, invalid_exc}, {32'h0000_0800, 2'b00});
      instr = mk_instr(9'h055);
      src_a = 64'h0000_0000_7FC0_0000;
      @(negedge clk);
      check("R9 idle NaN ignored", {stat_q, illegal_op, invalid_exc}, {32'h0000_0800, 2'b00});

      // R4 then R1 back to back, each a single-cycle pulse (R10)
      op_valid = 1'b1;
      @(negedge clk);
      check("R4 trap pulse", {stat_q, illegal_op, invalid_exc}, {32'h0000_0800, 2'b01});
      instr = mk_instr(9'h151);
      @(negedge clk);
      check("R1 upper selector bit illegal", {stat_q, illegal_op, invalid_exc}, {32'h0000_0800, 2'b10});
      op_valid = 1'b0;
      @(negedge clk);
      check("R10 flags clear", {stat_q, illegal_op, invalid_exc}, {32'h0000_0800, 2'b00});

      // R8: reset mid-run clears the condition
      rst_n = 1'b0;
      @(negedge clk);
      check("R8 reset clears", {stat_q, illegal_op, invalid_exc}, 34'd0);
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule